// File: doc/BRIEF.md
# Zoom and Pan Scan Address Generator

This block turns raster timing strobes into display-memory pixel addresses. For every visible pixel of a scan it produces a 20-bit linear address into a frame store whose lines are either 1024 or 1152 pixels wide. The address sequence starts at a programmable origin and can replicate each stored pixel both across and down the screen by an integer factor from 1 to 16. Small starting offsets let the first replicated pixel be entered part of the way through, so a zoomed image can be panned smoothly. A stop line turns replication off for the rest of the frame.

The pan and zoom controls are plain inputs held by the surrounding register logic. They are captured once per frame when the frame-start strobe arrives, and that copy governs the whole frame. Each line begins with a line-start strobe. Every cycle in which `active` is high yields one address, with `addr_vld` high, one cycle later.

Top module: `zoom_pan_addr`

## Requirements
- R1: While reset is asserted and after it is released, until the first active pixel, `addr_vld` is 0 and `pix_addr` is 0.
- R2: A cycle with `active`=1 and with both `line_start` and `frame_start` at 0 gives `addr_vld`=1 on the next cycle, with that pixel's address. Every other cycle gives `addr_vld`=0 on the next cycle.
- R3: The first pixel of the first line after `frame_start` has address `{org_hi, org_lo}`. `org_hi` holds bits 19:4 and `org_lo` holds bits 3:0.
- R4: When `res_code` equals 1 the line width is 1024. For every other code it is 1152. The base address of a line is the previous line's base plus the line width whenever the scan moves to a new stored line.
- R5: On a zoomed line the replication factor is `zoom_m1`+1. Within a line each address is repeated factor times before it increments by 1, and no address is repeated more than 16 times in a row.
- R6: On a zoomed line the first address of the line is output max(factor − 4·`pix_off`, 1) times. After that, each address is output factor times.
- R7: On zoomed lines the first stored line of the frame is used for max(factor − `line_off`, 1) scan lines. Every following stored line is used for factor scan lines.
- R8: Scan lines are counted from 0 at the first line after `frame_start`. Line n is zoomed when n < 4·`zoom_stop` (`zoom_stop` is 9 bits, 0 to 256). From line 4·`zoom_stop` onward the factor is 1 in both directions and the base advances by one line width on every line.
- R9: Changes to `org_hi`, `org_lo`, `zoom_m1`, `line_off`, `pix_off`, `zoom_stop` and `res_code` after the `frame_start` cycle have no effect on the addresses of that frame.
- R10: All address arithmetic wraps modulo 2^20.
- R11: Every `line_start` restarts the horizontal sequence at the new line base, even if the previous line was cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe; captures the controls and arms the first line |
| line_start | input | 1 | One-cycle strobe at the start of each scan line |
| active | input | 1 | High for each visible pixel cycle |
| org_hi | input | 16 | Origin address bits 19:4 |
| org_lo | input | 4 | Origin address bits 3:0 |
| zoom_m1 | input | 4 | Replication factor minus one |
| line_off | input | 4 | Starting row inside the first replicated pixel |
| pix_off | input | 4 | Starting column inside the first replicated pixel, in units of 4 |
| zoom_stop | input | 9 | Zoom stop line divided by 4 |
| res_code | input | 4 | Resolution code; 1 selects the 1024-wide layout |
| pix_addr | output | 20 | Linear pixel address |
| addr_vld | output | 1 | Marks `pix_addr` as a pixel address |

## Verification
Unzoomed frames with the origin at zero and at arbitrary values separate the origin split and the two line widths. Zoomed frames with zero offsets, followed by frames with nonzero column and row offsets, show whether the replication counters start at the right phase, because the length of the first run changes while the later runs do not. Frames whose stop line falls part way down the scan expose the point where zooming ends. An origin just below 2^20 checks the wrap. Controls changed right after the frame strobe must leave the address stream unchanged. Seeded random configurations then mix all these effects together.

// File: rtl/zoom_pan_addr.sv
module zoom_pan_addr #(
  parameter int AW        = 20,
  parameter int HI_W      = 16,
  parameter int ZW        = 4,
  parameter int STOPW     = 9,
  parameter int WIDE_LINE = 1152,
  parameter int SQ_LINE   = 1024,
  parameter logic [3:0] SQ_CODE = 4'd1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               line_start,
  input  logic               active,
  input  logic [HI_W-1:0]    org_hi,
  input  logic [AW-HI_W-1:0] org_lo,
  input  logic [ZW-1:0]      zoom_m1,
  input  logic [ZW-1:0]      line_off,
  input  logic [ZW-1:0]      pix_off,
  input  logic [STOPW-1:0]   zoom_stop,
  input  logic [3:0]         res_code,
  output logic [AW-1:0]      pix_addr,
  output logic               addr_vld
);
  localparam int LCW = STOPW + 2;
  localparam int HCW = ZW + 3;
  localparam int VCW = ZW + 1;

  logic [AW-1:0]  org_q, wid_q, base_q, haddr_q;
  logic [ZW-1:0]  zm1_q, loff_q;
  logic [HCW-1:0] poff_q, hcnt_q;
  logic [LCW-1:0] stop_q, lcnt_q, lcnt_nxt;
  logic [VCW-1:0] vcnt_q;
  logic           first_q, zm_line_q;
  logic           new_line, pix_cyc, vadv, hstep;
  logic [AW-1:0]  base_nxt;

  assign new_line = line_start & ~frame_start;
  assign pix_cyc  = active & ~line_start & ~frame_start;
  assign lcnt_nxt = first_q ? '0 : ((&lcnt_q) ? lcnt_q : lcnt_q + 1'b1);
  assign vadv     = ~zm_line_q | (vcnt_q >= VCW'(zm1_q));
  assign hstep    = ~zm_line_q | (hcnt_q >= HCW'(zm1_q));
  assign base_nxt = first_q ? org_q : (vadv ? base_q + wid_q : base_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      org_q  <= '0;
      wid_q  <= AW'(WIDE_LINE);
      zm1_q  <= '0;
      loff_q <= '0;
      poff_q <= '0;
      stop_q <= '0;
    end else if (frame_start) begin
      org_q  <= {org_hi, org_lo};
      wid_q  <= (res_code == SQ_CODE) ? AW'(SQ_LINE) : AW'(WIDE_LINE);
      zm1_q  <= zoom_m1;
      loff_q <= line_off;
      poff_q <= HCW'({pix_off, 2'b00});
      stop_q <= {zoom_stop, 2'b00};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q   <= 1'b1;
      lcnt_q    <= '0;
      base_q    <= '0;
      vcnt_q    <= '0;
      zm_line_q <= 1'b0;
    end else if (frame_start) begin
      first_q <= 1'b1;
    end else if (new_line) begin
      first_q   <= 1'b0;
      lcnt_q    <= lcnt_nxt;
      base_q    <= base_nxt;
      vcnt_q    <= first_q ? VCW'(loff_q) : (vadv ? '0 : vcnt_q + 1'b1);
      zm_line_q <= lcnt_nxt < stop_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      haddr_q <= '0;
      hcnt_q  <= '0;
    end else if (new_line) begin
      haddr_q <= base_nxt;
      hcnt_q  <= poff_q;
    end else if (pix_cyc) begin
      haddr_q <= hstep ? haddr_q + 1'b1 : haddr_q;
      hcnt_q  <= hstep ? '0 : hcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_addr <= '0;
      addr_vld <= 1'b0;
    end else begin
      addr_vld <= pix_cyc;
      if (pix_cyc) pix_addr <= haddr_q;
    end
  end
endmodule

// File: rtl/zoom_pan_addr_chk.sv
module zoom_pan_addr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_start,
  input logic        line_start,
  input logic        active,
  input logic        addr_vld,
  input logic [19:0] pix_addr,
  input logic        zm_line
);
  logic [19:0] prev_addr;
  logic        prev_vld;
  logic [5:0]  run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_addr <= '0;
      prev_vld  <= 1'b0;
      run_q     <= '0;
    end else begin
      prev_addr <= pix_addr;
      prev_vld  <= addr_vld;
      if (!addr_vld) run_q <= '0;
      else if (prev_vld && pix_addr == prev_addr) run_q <= (run_q == 6'h3f) ? run_q : run_q + 1'b1;
      else run_q <= 6'd1;
    end
  end

  AST_VLD_AFTER_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !line_start && !frame_start) |=> addr_vld); // R2
  AST_NO_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(active && !line_start && !frame_start) |=> !addr_vld); // R2
  AST_UNZOOMED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && prev_vld && !zm_line) |-> (pix_addr == prev_addr + 20'd1)); // R8
  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && prev_vld) |-> ((pix_addr - prev_addr) <= 20'd1)); // R5
  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 6'd16); // R5
endmodule

bind zoom_pan_addr zoom_pan_addr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
  .active(active), .addr_vld(addr_vld), .pix_addr(pix_addr), .zm_line(zm_line_q)
);

// File: tb/zoom_pan_addr_tb.sv
module zoom_pan_addr_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 0, line_start = 0, active = 0;
  logic [15:0] org_hi = 0;
  logic [3:0]  org_lo = 0, zoom_m1 = 0, line_off = 0, pix_off = 0, res_code = 0;
  logic [8:0]  zoom_stop = 0;
  logic [19:0] pix_addr;
  logic        addr_vld;

  int total = 0, bad = 0, seen = 0;
  string cur_tag = "R2";
  logic [19:0] exp_q[$];

  int c_org, c_w, c_zf, c_loff, c_poff, c_stop;

  always #5 clk = ~clk;

  zoom_pan_addr u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .active(active), .org_hi(org_hi), .org_lo(org_lo), .zoom_m1(zoom_m1),
    .line_off(line_off), .pix_off(pix_off), .zoom_stop(zoom_stop), .res_code(res_code),
    .pix_addr(pix_addr), .addr_vld(addr_vld)
  );

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic bit zoomed(int l);
    return l < 4 * c_stop;
  endfunction

  function automatic logic [19:0] exp_addr(int l, int p);
    int base = c_org, left = imax(c_zf - c_loff, 1), r0;
    for (int k = 1; k <= l; k++) begin
      if (zoomed(k - 1)) begin
        left--;
        if (left == 0) begin base += c_w; left = c_zf; end
      end else base += c_w;
    end
    if (!zoomed(l)) return 20'(base + p);
    r0 = imax(c_zf - 4 * c_poff, 1);
    if (p < r0) return 20'(base);
    return 20'(base + 1 + (p - r0) / c_zf);
  endfunction

  always @(negedge clk) begin
    if (rst_n && addr_vld) begin
      total++;
      seen++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL %s: unexpected valid, addr=%h expected no valid", cur_tag, pix_addr);
      end else begin
        logic [19:0] e;
        e = exp_q.pop_front();
        if (pix_addr !== e) begin
          bad++;
          $display("FAIL %s: addr=%h expected=%h", cur_tag, pix_addr, e);
        end
      end
    end
  end

  task automatic set_cfg(int org, int res, int zm1, int loff, int poff, int stop);
    {org_hi, org_lo} = 20'(org);
    res_code = 4'(res); zoom_m1 = 4'(zm1); line_off = 4'(loff);
    pix_off = 4'(poff); zoom_stop = 9'(stop);
    c_org = org & 20'hfffff; c_w = (res == 1) ? 1024 : 1152; c_zf = zm1 + 1;
    c_loff = loff; c_poff = poff; c_stop = stop;
  endtask

  task automatic run_frame(string tag, int nlines, int npix, bit perturb);
    int expected;
    cur_tag = tag;
    seen = 0;
    @(negedge clk) frame_start = 1;
    @(negedge clk) frame_start = 0;
    if (perturb) begin
      {org_hi, org_lo} = 20'($urandom); zoom_m1 = 4'($urandom); line_off = 4'($urandom);
      pix_off = 4'($urandom); zoom_stop = 9'($urandom); res_code = 4'($urandom);
    end
    for (int l = 0; l < nlines; l++) begin
      @(negedge clk) line_start = 1;
      @(negedge clk) line_start = 0;
      for (int p = 0; p < npix; p++) begin
        exp_q.push_back(exp_addr(l, p));
        active = 1;
        @(negedge clk);
      end
      active = 0;
      @(negedge clk);
      @(negedge clk);
    end
    expected = nlines * npix;
    total++;
    if (seen != expected) begin
      bad++;
      $display("FAIL R2: %s frame valid count=%0d expected=%0d", tag, seen, expected);
    end
    exp_q.delete();
  endtask

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    total++;
    if (addr_vld !== 1'b0 || pix_addr !== 20'd0) begin
      bad++;
      $display("FAIL R1: vld=%b addr=%h expected vld=0 addr=0", addr_vld, pix_addr);
    end
    rst_n = 1;
    @(negedge clk);
    total++;
    if (addr_vld !== 1'b0 || pix_addr !== 20'd0) begin
      bad++;
      $display("FAIL R1: after release vld=%b addr=%h expected 0", addr_vld, pix_addr);
    end

    set_cfg(0, 1, 0, 0, 0, 0);            run_frame("R3", 3, 12, 0);
    set_cfg(20'h12345, 0, 0, 0, 0, 0);    run_frame("R4", 3, 12, 0);
    set_cfg(20'h00107, 2, 2, 0, 0, 256);  run_frame("R5", 7, 20, 0);
    set_cfg(20'h00040, 1, 7, 0, 1, 256);  run_frame("R6", 3, 24, 0);
    set_cfg(20'h00040, 0, 3, 0, 3, 256);  run_frame("R6", 2, 16, 0);
    set_cfg(20'h00200, 0, 3, 2, 0, 256);  run_frame("R7", 8, 10, 0);
    set_cfg(20'h00200, 1, 4, 9, 0, 256);  run_frame("R7", 7, 10, 0);
    set_cfg(20'h00300, 1, 2, 1, 0, 1);    run_frame("R8", 8, 10, 0);
    set_cfg(20'h00300, 0, 5, 0, 1, 0);    run_frame("R8", 4, 10, 0);
    set_cfg(20'hfff00, 0, 1, 0, 0, 256);  run_frame("R10", 3, 300, 0);
    set_cfg(20'hffff8, 1, 15, 0, 0, 256); run_frame("R5", 2, 40, 0);
    set_cfg(20'h0abcd, 0, 2, 1, 1, 1);    run_frame("R9", 6, 14, 1);

    // R11: a line cut short, then a fresh line restarts at the next base
    set_cfg(20'h00500, 0, 0, 0, 0, 0);
    run_frame("R11", 2, 3, 0);

    for (int i = 0; i < 20; i++) begin
      int st;
      st = ($urandom % 5 == 0) ? 256 : int'($urandom % 3);
      set_cfg(int'($urandom), int'($urandom % 4), int'($urandom % 16),
              int'($urandom % 16), int'($urandom % 16), st);
      run_frame("R5", 3 + int'($urandom % 7), 8 + int'($urandom % 33), i[0]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule